// File: doc/BRIEF.md
# Bus Cycle Timer with Timestamp Pin

The block keeps a 32-bit bus cycle timer and shares one bidirectional timestamp pin between two roles. The timer holds seconds, a cycle count and a sub-cycle offset. A per-offset tick from the bus clock domain advances it, and it can be loaded in one step: a cycle master sets its own time this way, and a cycle slave takes the time from a cycle-start packet.

In transmit mode the pin is an input. A falling edge on it, after a two-flop synchronizer, copies the timer into a capture register and pulses a strobe. In receive mode the block drives the pin. Whenever the timer is updated to a value whose low 16 bits (low cycle bits and offset) equal a programmed timestamp, the pin carries a fixed-width active-low pulse. Outside receive mode the pin is released.

Top module: `cyc_ts_timer`

## Requirements
- R1: The timer packs seconds in bits [31:25], cycle count in [24:12] and offset in [11:0]. It resets to zero. Each cycle with `tick_i` high and no load adds one to the offset. With neither tick nor load, it holds its value.
- R2: The offset steps from 3071 to 0 and carries one into the cycle count. The cycle count steps from 7999 to 0 and carries one into the seconds. The seconds field steps from 127 to 0.
- R3: With `load_en_i` high, the timer takes `load_val_i` at the next edge, and that load overrides a tick in the same cycle.
- R4: In transmit mode (`rx_mode_i` = 0), a falling edge on `ts_pin_i` makes `capture_o` take the timer value and `capture_stb_o` go high for one cycle. Both happen on the third rising clock edge after the pin goes low.
- R5: A single falling edge gives exactly one capture. A pin that stays low or rises causes no capture, and `capture_o` then keeps its value.
- R6: `ts_pin_oe_o` is low out of reset and in transmit mode. It goes high one edge after `rx_mode_i` rises. `ts_pin_o` is high whenever no pulse is active, and is low only while `ts_pin_oe_o` is high.
- R7: In receive mode, a timer update by tick or load to a value whose bits [15:0] equal `match_val_i` drives `ts_pin_o` low. The pulse starts at the next edge and lasts exactly PULSE_LEN cycles (default 32).
- R8: A match that occurs while a pulse is active neither extends nor restarts it. A timer that stays at a matching value without an update starts no pulse.
- R9: While the pin is in the output role, falling edges on it, including the block's own pulse, never cause a capture.
- R10: When `rx_mode_i` falls, the next edge ends any active pulse, sets `ts_pin_o` high and drops `ts_pin_oe_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Advance the offset by one |
| load_en_i | input | 1 | Load the timer from load_val_i |
| load_val_i | input | 32 | Timer load value |
| rx_mode_i | input | 1 | 1: pin drives match pulses, 0: pin captures |
| match_val_i | input | 16 | Timestamp compared with timer bits [15:0] |
| ts_pin_i | input | 1 | Pad input of the timestamp pin |
| ts_pin_o | output | 1 | Pad output value, low during a match pulse |
| ts_pin_oe_o | output | 1 | Pad output enable |
| timer_o | output | 32 | Current timer |
| capture_o | output | 32 | Timer value at the last capture |
| capture_stb_o | output | 1 | One-cycle strobe on a new capture |

## Verification
The bound checker tests the following on every cycle: offset and cycle wrap with carry, load priority and hold, a capture register that changes only with its strobe, single-cycle strobes, no capture while the pin was being driven, no low output without enable, and release one edge after receive mode ends. Only the bench scenarios can show the exact three-edge capture latency, the precise pulse width, and that a match arriving mid-pulse or a stopped timer sitting on the timestamp starts no extra pulse. Those checks need counts over whole windows.

// File: rtl/cyc_ts_pkg.sv
package cyc_ts_pkg;
  localparam int SEC_W   = 7;
  localparam int CYC_W   = 13;
  localparam int OFF_W   = 12;
  localparam int TMR_W   = SEC_W + CYC_W + OFF_W;
  localparam int CYC_MOD = 8000;
  localparam int OFF_MOD = 3072;
  localparam int SEC_MOD = 1 << SEC_W;
  localparam int CMP_W   = 16;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [CYC_W-1:0] cyc;
    logic [OFF_W-1:0] off;
  } tmr_t;
endpackage

// File: rtl/cyc_ts_field.sv
module cyc_ts_field #(
  parameter int W   = 12,
  parameter int MOD = 3072
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         load_en_i,
  input  logic [W-1:0] load_i,
  output logic [W-1:0] val_o,
  output logic         carry_o
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  logic [W-1:0] val_q;

  assign carry_o = inc_i & (val_q == LAST);
  assign val_o   = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        val_q <= '0;
    else if (load_en_i) val_q <= load_i;
    else if (inc_i)     val_q <= (val_q == LAST) ? '0 : val_q + 1'b1;
  end
endmodule

// File: rtl/cyc_ts_counter.sv
module cyc_ts_counter
  import cyc_ts_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic load_en_i,
  input  tmr_t load_i,
  output tmr_t tmr_o,
  output logic upd_o
);
  logic off_carry, cyc_carry, sec_carry;
  logic upd_q;

  cyc_ts_field #(.W(OFF_W), .MOD(OFF_MOD)) u_off (
    .clk_i, .rst_ni,
    .inc_i     (tick_i & ~load_en_i),
    .load_en_i (load_en_i),
    .load_i    (load_i.off),
    .val_o     (tmr_o.off),
    .carry_o   (off_carry)
  );

  cyc_ts_field #(.W(CYC_W), .MOD(CYC_MOD)) u_cyc (
    .clk_i, .rst_ni,
    .inc_i     (off_carry),
    .load_en_i (load_en_i),
    .load_i    (load_i.cyc),
    .val_o     (tmr_o.cyc),
    .carry_o   (cyc_carry)
  );

  cyc_ts_field #(.W(SEC_W), .MOD(SEC_MOD)) u_sec (
    .clk_i, .rst_ni,
    .inc_i     (cyc_carry),
    .load_en_i (load_en_i),
    .load_i    (load_i.sec),
    .val_o     (tmr_o.sec),
    .carry_o   (sec_carry)
  );

  // a seconds rollover has no further consumer
  logic sec_wrap_unused;
  assign sec_wrap_unused = sec_carry;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upd_q <= 1'b0;
    else         upd_q <= tick_i | load_en_i;
  end
  assign upd_o = upd_q;
endmodule

// File: rtl/cyc_ts_sync_edge.sv
module cyc_ts_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  // idle level is high: reset to 1 so release from reset is not an edge
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '1;
        else         sh_q <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '1;
        else         sh_q <= {sh_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sh_q[STAGES-1];
  end

  assign fall_o = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/cyc_ts_pulse.sv
module cyc_ts_pulse #(
  parameter int LEN = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic trig_i,
  output logic act_o,
  output logic oe_o
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

  logic [CW-1:0] cnt_q;
  logic          act_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= en_i;
      if (!en_i) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else if (act_q) begin
        if (cnt_q == '0) act_q <= 1'b0;
        else             cnt_q <= cnt_q - 1'b1;
      end else if (trig_i) begin
        act_q <= 1'b1;
        cnt_q <= CW'(LEN - 1);
      end
    end
  end

  assign act_o = act_q;
  assign oe_o  = oe_q;
endmodule

// File: rtl/cyc_ts_timer.sv
module cyc_ts_timer
  import cyc_ts_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_LEN   = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_en_i,
  input  logic [TMR_W-1:0] load_val_i,
  input  logic             rx_mode_i,
  input  logic [CMP_W-1:0] match_val_i,
  input  logic             ts_pin_i,
  output logic             ts_pin_o,
  output logic             ts_pin_oe_o,
  output logic [TMR_W-1:0] timer_o,
  output logic [TMR_W-1:0] capture_o,
  output logic             capture_stb_o
);
  tmr_t tmr;
  logic upd, fall, hit, act, oe, cap_en;
  logic [TMR_W-1:0] cap_q;
  logic             stb_q;

  cyc_ts_counter u_cnt (
    .clk_i, .rst_ni,
    .tick_i    (tick_i),
    .load_en_i (load_en_i),
    .load_i    (tmr_t'(load_val_i)),
    .tmr_o     (tmr),
    .upd_o     (upd)
  );

  cyc_ts_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i, .rst_ni,
    .pin_i  (ts_pin_i),
    .fall_o (fall)
  );

  // match only on a fresh timer value, never on a stopped one
  assign hit = upd & (tmr[CMP_W-1:0] == match_val_i);

  cyc_ts_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk_i, .rst_ni,
    .en_i   (rx_mode_i),
    .trig_i (hit),
    .act_o  (act),
    .oe_o   (oe)
  );

  // both the mode and the registered enable must be off to capture
  assign cap_en = fall & ~rx_mode_i & ~oe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= cap_en;
      if (cap_en) cap_q <= tmr;
    end
  end

  assign timer_o       = tmr;
  assign capture_o     = cap_q;
  assign capture_stb_o = stb_q;
  assign ts_pin_o      = ~act;
  assign ts_pin_oe_o   = oe;
endmodule

// File: rtl/cyc_ts_timer_chk.sv
module cyc_ts_timer_chk
  import cyc_ts_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             load_en_i,
  input logic [TMR_W-1:0] load_val_i,
  input logic             rx_mode_i,
  input logic             ts_pin_o,
  input logic             ts_pin_oe_o,
  input logic [TMR_W-1:0] timer_o,
  input logic [TMR_W-1:0] capture_o,
  input logic             capture_stb_o
);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(OFF_MOD - 1);
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_MOD - 1);

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !load_en_i |=> $stable(timer_o)); // R1

  AST_OFF_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !load_en_i && timer_o[OFF_W-1:0] == OFF_LAST
    |=> timer_o[OFF_W-1:0] == '0); // R2

  AST_CYC_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !load_en_i && timer_o[OFF_W-1:0] == OFF_LAST
      && timer_o[OFF_W+CYC_W-1:OFF_W] == CYC_LAST
    |=> timer_o[OFF_W+CYC_W-1:OFF_W] == '0
      && timer_o[TMR_W-1:OFF_W+CYC_W] == $past(timer_o[TMR_W-1:OFF_W+CYC_W]) + 1'b1); // R2

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |=> timer_o == $past(load_val_i)); // R3

  AST_CAP_WITH_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_stb_o |-> $stable(capture_o)); // R4

  AST_STB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_stb_o |=> !capture_stb_o); // R5

  AST_LOW_NEEDS_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ts_pin_o |-> ts_pin_oe_o); // R6

  AST_NO_CAP_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ts_pin_oe_o) |-> !capture_stb_o); // R9

  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_mode_i |=> !ts_pin_oe_o && ts_pin_o); // R10
endmodule

bind cyc_ts_timer cyc_ts_timer_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tick_i        (tick_i),
  .load_en_i     (load_en_i),
  .load_val_i    (load_val_i),
  .rx_mode_i     (rx_mode_i),
  .ts_pin_o      (ts_pin_o),
  .ts_pin_oe_o   (ts_pin_oe_o),
  .timer_o       (timer_o),
  .capture_o     (capture_o),
  .capture_stb_o (capture_stb_o)
);

// File: tb/cyc_ts_timer_bench.sv
`timescale 1ns/1ps
module cyc_ts_timer_bench;
  localparam int PL = 32;
  localparam int NV = 7;

  function automatic logic [31:0] tm(input int s, input int c, input int o);
    return {7'(s), 13'(c), 12'(o)};
  endfunction

  localparam logic [31:0] V_LOAD [NV] = '{tm(0,0,5), tm(0,3,3071), tm(5,7999,3071),
    tm(127,7999,3071), tm(2,100,3070), tm(9,7999,3069), tm(1,2,3)};
  localparam int          V_TICK [NV] = '{3, 1, 1, 1, 3, 4, 0};
  localparam logic [31:0] V_EXP  [NV] = '{tm(0,0,8), tm(0,4,0), tm(6,0,0),
    tm(0,0,0), tm(2,101,1), tm(10,0,1), tm(1,2,3)};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, load_en = 1'b0, rx_mode = 1'b0, pin_drv = 1'b1;
  logic [31:0] load_val = '0;
  logic [15:0] match_val = '0;
  logic pin_o, pin_oe, stb;
  logic [31:0] timer, cap;
  logic pad;

  int n_chk = 0, n_fail = 0;
  int stb_cnt = 0, low_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign pad = pin_oe ? pin_o : pin_drv;

  cyc_ts_timer #(.SYNC_STAGES(2), .PULSE_LEN(PL)) u_cyc_ts_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .load_en_i(load_en),
    .load_val_i(load_val), .rx_mode_i(rx_mode), .match_val_i(match_val),
    .ts_pin_i(pad), .ts_pin_o(pin_o), .ts_pin_oe_o(pin_oe),
    .timer_o(timer), .capture_o(cap), .capture_stb_o(stb)
  );

  always @(negedge clk) begin
    if (stb) stb_cnt++;
    if (pin_oe && !pin_o) low_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [31:0] v);
    load_en = 1'b1; load_val = v;
    @(negedge clk);
    load_en = 1'b0;
    chk("R3 load", timer, v);
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    int s0;
    idle(3);
    // reset state: R1, R6
    chk("R1 reset timer", timer, 32'h0);
    chk("R6 reset oe", {31'd0, pin_oe}, 32'd0);
    chk("R6 reset pin level", {31'd0, pin_o}, 32'd1);
    chk("R4 reset strobe", {31'd0, stb}, 32'd0);
    rst_n = 1'b1;
    idle(2);

    // vector table: R1, R2, R3
    for (int v = 0; v < NV; v++) begin
      do_load(V_LOAD[v]);
      do_ticks(V_TICK[v]);
      chk((v == 0 || v == 6) ? "R1 count/hold" : "R2 wrap/carry", timer, V_EXP[v]);
    end

    // load beats tick in the same cycle: R3
    load_en = 1'b1; tick = 1'b1; load_val = tm(4,4,4);
    @(negedge clk);
    load_en = 1'b0; tick = 1'b0;
    chk("R3 load over tick", timer, tm(4,4,4));

    // capture: R4, R5
    do_load(tm(3,1234,567));
    s0 = stb_cnt;
    pin_drv = 1'b0;
    idle(2);
    chk("R4 no strobe before third edge", {31'd0, stb}, 32'd0);
    idle(1);
    chk("R4 strobe on third edge", {31'd0, stb}, 32'd1);
    chk("R4 captured value", cap, tm(3,1234,567));
    idle(6);
    chk("R5 one capture per fall", stb_cnt - s0, 1);
    do_load(tm(3,1234,600));
    pin_drv = 1'b1;
    idle(6);
    chk("R5 rise gives no capture", stb_cnt - s0, 1);
    chk("R5 capture kept", cap, tm(3,1234,567));
    pin_drv = 1'b0;
    idle(4);
    chk("R4 second capture", cap, tm(3,1234,600));
    pin_drv = 1'b1;
    idle(4);

    // match pulse: R6, R7, R8, R9
    do_load(tm(0,2,'h0FE));
    match_val = 16'h20FF;
    rx_mode = 1'b1;
    @(negedge clk);
    chk("R6 oe after mode", {31'd0, pin_oe}, 32'd1);
    chk("R6 idle high", {31'd0, pin_o}, 32'd1);
    s0 = stb_cnt;
    low_cnt = 0;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk("R7 no low before next edge", {31'd0, pin_o}, 32'd1);
    chk("R7 timer at stamp", timer, tm(0,2,'h0FF));
    idle(PL + 6);
    chk("R7 pulse width", low_cnt, PL);
    chk("R9 no capture of own pulse", stb_cnt - s0, 0);

    // retrigger mid-pulse: R8
    do_load(tm(0,2,'h0FE));
    low_cnt = 0;
    do_ticks(1);
    idle(4);
    do_load(tm(0,2,'h0FF));
    idle(PL + 6);
    chk("R8 no extension", low_cnt, PL);

    // abort by leaving receive mode: R10
    do_load(tm(0,2,'h0FE));
    do_ticks(1);
    idle(3);
    chk("R7 pulse active", {31'd0, pin_o}, 32'd0);
    rx_mode = 1'b0;
    @(negedge clk);
    chk("R10 oe dropped", {31'd0, pin_oe}, 32'd0);
    chk("R10 level high", {31'd0, pin_o}, 32'd1);
    idle(6);
    chk("R9 no capture after release", stb_cnt - s0, 0);

    // stopped timer on the stamp: R8
    low_cnt = 0;
    rx_mode = 1'b1;
    idle(PL);
    chk("R8 stopped timer no pulse", low_cnt, 0);
    rx_mode = 1'b0;
    idle(2);

    done = 1;
    report();
    $finish;
  end
endmodule